// File: doc/BRIEF.md
# Receive Arrival-Time Header Inserter

This block sits in a receive byte path and marks each incoming frame with the time it arrived. A frame comes in as a stream of bytes with start and end flags. When stamping is turned on both for the whole block and for the queue that owns the frame, the block samples its clock inputs at the start of the frame. It then emits a 16-byte header ahead of the unchanged frame bytes. Every frame on an enabled queue is stamped, whatever it contains.

The header holds two 64-bit time slots. Each queue has two selectors that choose which clock source fills the first slot and which fills the second. Each slot is written least significant byte first. While the header is going out, the block holds off its input so that no frame byte is lost. If either enable is clear, the frame passes straight through: same bytes, same flags, no added latency.

Top module: `rxts_prepend`

## Requirements
- R1: After reset, with no input offered, out_valid and out_sof are low and in_ready follows out_ready.
- R2: A stamped frame leaves as exactly 16 header bytes followed by every input byte in order with its value unchanged.
- R3: Header bytes 0 to 7 carry the first slot and bytes 8 to 15 carry the second slot. Within a slot, byte k holds bits 8k+7 down to 8k of the 64-bit time, so the low 32-bit word comes before the high word.
- R4: Within timer_bus, source n occupies bits 64n+63 down to 64n. For queue q, fields q of q_sel0 and q_sel1 pick the source for the first and second slot. Setting both fields to 0 puts source 0 in both slots.
- R5: With stamp_en low, frames pass through unchanged, with the same bytes, start flag and end flag.
- R6: A frame on a queue whose bit in q_stamp_en is low passes through unchanged even while stamp_en is high.
- R7: The header carries the time sources as they were in the cycle when the start byte of the frame was first presented while the block was idle. Later changes to the sources do not alter it.
- R8: in_ready is low from the cycle the stamped start byte is first presented until the last header byte is taken, so no input byte is accepted during that time. With out_ready held high, the start byte is accepted on the 17th cycle after it is first presented. Output data holds steady while out_ready is low.
- R9: For a stamped frame, out_sof is high only on header byte 0. out_eof is high only on the output byte that carries the input's end-flagged byte, and this also holds for a one-byte frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stamp_en | input | 1 | Global stamping enable |
| q_stamp_en | input | NUM_QUEUES | Per-queue stamping enable |
| q_sel0 | input | NUM_QUEUES*SELW | Per-queue source select for the first slot |
| q_sel1 | input | NUM_QUEUES*SELW | Per-queue source select for the second slot |
| timer_bus | input | NUM_TIMERS*TIME_W | Time sources, source n in slice n |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| in_queue | input | QW | Receive queue of the frame, sampled with the start byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is first of frame |
| out_eof | output | 1 | Output byte is last of frame |

## Verification
The hardest case to reach is a header that must stay frozen while the time sources keep moving and the output is stalled part way through. The header has to show the time from the cycle the start byte first appeared, not from the cycle it was finally accepted. The bench advances both sources on every clock and throttles out_ready in a repeating pattern. It notes the source values in the cycle it first offers the start byte and compares every header byte against that note. One-byte frames and different per-queue selector settings cover the flag handling and the slot routing.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_HDR  = 2'd1,
      RX_BODY = 2'd2
   } rxts_state_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/rxts_cfg_decode.sv
module rxts_cfg_decode #(
   parameter int unsigned NUM_QUEUES = 4,
   parameter int unsigned SELW       = 1,
   parameter int unsigned QW         = 2
) (
   input  logic [NUM_QUEUES-1:0]      q_en_i,
   input  logic [NUM_QUEUES*SELW-1:0] sel0_flat_i,
   input  logic [NUM_QUEUES*SELW-1:0] sel1_flat_i,
   input  logic [QW-1:0]              queue_i,
   output logic                       en_o,
   output logic [SELW-1:0]            sel0_o,
   output logic [SELW-1:0]            sel1_o
);
   logic [SELW-1:0] sel0_arr [NUM_QUEUES];
   logic [SELW-1:0] sel1_arr [NUM_QUEUES];

   for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_unpack
      assign sel0_arr[g] = sel0_flat_i[g*SELW +: SELW];
      assign sel1_arr[g] = sel1_flat_i[g*SELW +: SELW];
   end

   // A queue index beyond the configured count never stamps.
   always_comb begin
      en_o   = 1'b0;
      sel0_o = '0;
      sel1_o = '0;
      for (int k = 0; k < NUM_QUEUES; k++) begin
         if (queue_i == QW'(k)) begin
            en_o   = q_en_i[k];
            sel0_o = sel0_arr[k];
            sel1_o = sel1_arr[k];
         end
      end
   end
endmodule

// File: rtl/rxts_time_select.sv
module rxts_time_select #(
   parameter int unsigned TIME_W     = 64,
   parameter int unsigned NUM_TIMERS = 2,
   parameter int unsigned SELW       = 1
) (
   input  logic [NUM_TIMERS*TIME_W-1:0] timers_i,
   input  logic [SELW-1:0]              sel_i,
   output logic [TIME_W-1:0]            time_o
);
   // An out-of-range select falls back to source 0.
   always_comb begin
      time_o = timers_i[TIME_W-1:0];
      for (int k = 1; k < NUM_TIMERS; k++) begin
         if (sel_i == SELW'(k)) time_o = timers_i[k*TIME_W +: TIME_W];
      end
   end
endmodule

// File: rtl/rxts_hdr_shift.sv
module rxts_hdr_shift #(
   parameter int unsigned TIME_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                adv_i,
   input  logic [TIME_W-1:0]   slot0_i,
   input  logic [TIME_W-1:0]   slot1_i,
   output logic [7:0]          byte_o,
   output logic                first_o,
   output logic                last_o,
   output logic [2*TIME_W-1:0] hdr_o
);
   localparam int unsigned HDR_BYTES = 2 * TIME_W / 8;
   localparam int unsigned CW        = $clog2(HDR_BYTES);

   logic [2*TIME_W-1:0] hdr_q;
   logic [CW-1:0]       cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         hdr_q <= {slot1_i, slot0_i};
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      end
   end

   assign byte_o  = hdr_q[{cnt_q, 3'b000} +: 8];
   assign first_o = (cnt_q == '0);
   assign last_o  = (cnt_q == CW'(HDR_BYTES - 1));
   assign hdr_o   = hdr_q;
endmodule

// File: rtl/rxts_ctrl.sv
module rxts_ctrl
   import rxts_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stamp_ok_i,
   input  logic       in_valid_i,
   input  logic [7:0] in_data_i,
   input  logic       in_sof_i,
   input  logic       in_eof_i,
   output logic       in_ready_o,
   input  logic       out_ready_i,
   output logic       out_valid_o,
   output logic [7:0] out_data_o,
   output logic       out_sof_o,
   output logic       out_eof_o,
   input  logic [7:0] hdr_byte_i,
   input  logic       hdr_first_i,
   input  logic       hdr_last_i,
   output logic       load_o,
   output logic       adv_o,
   output logic       hdr_active_o
);
   rxts_state_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= RX_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d        = st_q;
      out_valid_o = in_valid_i;
      out_data_o  = in_data_i;
      out_sof_o   = in_sof_i;
      out_eof_o   = in_eof_i;
      in_ready_o  = out_ready_i;
      load_o      = 1'b0;
      adv_o       = 1'b0;
      unique case (st_q)
         RX_IDLE: begin
            if (in_valid_i && in_sof_i && stamp_ok_i) begin
               load_o      = 1'b1;
               out_valid_o = 1'b0;
               out_sof_o   = 1'b0;
               out_eof_o   = 1'b0;
               in_ready_o  = 1'b0;
               st_d        = RX_HDR;
            end else if (in_valid_i && out_ready_i && in_sof_i && !in_eof_i) begin
               st_d = RX_BODY;
            end
         end
         RX_HDR: begin
            out_valid_o = 1'b1;
            out_data_o  = hdr_byte_i;
            out_sof_o   = hdr_first_i;
            out_eof_o   = 1'b0;
            in_ready_o  = 1'b0;
            if (out_ready_i) begin
               adv_o = 1'b1;
               if (hdr_last_i) st_d = RX_BODY;
            end
         end
         RX_BODY: begin
            out_sof_o = 1'b0;
            if (in_valid_i && out_ready_i && in_eof_i) st_d = RX_IDLE;
         end
         default: st_d = RX_IDLE;
      endcase
   end

   assign hdr_active_o = (st_q == RX_HDR);
endmodule

// File: rtl/rxts_prepend.sv
module rxts_prepend #(
   parameter int unsigned TIME_W     = 64,
   parameter int unsigned NUM_TIMERS = 2,
   parameter int unsigned NUM_QUEUES = 4,
   parameter int unsigned SELW       = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
   parameter int unsigned QW         = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         stamp_en,
   input  logic [NUM_QUEUES-1:0]        q_stamp_en,
   input  logic [NUM_QUEUES*SELW-1:0]   q_sel0,
   input  logic [NUM_QUEUES*SELW-1:0]   q_sel1,
   input  logic [NUM_TIMERS*TIME_W-1:0] timer_bus,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [7:0]                   in_data,
   input  logic                         in_sof,
   input  logic                         in_eof,
   input  logic [QW-1:0]                in_queue,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [7:0]                   out_data,
   output logic                         out_sof,
   output logic                         out_eof
);
   if (TIME_W % 32 != 0 || TIME_W == 0) begin : g_bad_time_w
      $error("TIME_W must be a nonzero multiple of 32");
   end
   if (NUM_TIMERS < 1) begin : g_bad_timers
      $error("NUM_TIMERS must be at least 1");
   end
   if (NUM_QUEUES < 1) begin : g_bad_queues
      $error("NUM_QUEUES must be at least 1");
   end
   if ((1 << SELW) < NUM_TIMERS) begin : g_bad_selw
      $error("SELW too narrow for NUM_TIMERS");
   end

   logic                q_en;
   logic [SELW-1:0]     sel0, sel1;
   logic [TIME_W-1:0]   slot0, slot1;
   logic [7:0]          hdr_byte;
   logic                hdr_first, hdr_last;
   logic                load, adv;
   logic                hdr_active;
   logic [2*TIME_W-1:0] hdr_word;

   rxts_cfg_decode #(.NUM_QUEUES(NUM_QUEUES), .SELW(SELW), .QW(QW)) u_cfg (
      .q_en_i(q_stamp_en), .sel0_flat_i(q_sel0), .sel1_flat_i(q_sel1),
      .queue_i(in_queue), .en_o(q_en), .sel0_o(sel0), .sel1_o(sel1)
   );

   rxts_time_select #(.TIME_W(TIME_W), .NUM_TIMERS(NUM_TIMERS), .SELW(SELW)) u_sel0 (
      .timers_i(timer_bus), .sel_i(sel0), .time_o(slot0)
   );

   rxts_time_select #(.TIME_W(TIME_W), .NUM_TIMERS(NUM_TIMERS), .SELW(SELW)) u_sel1 (
      .timers_i(timer_bus), .sel_i(sel1), .time_o(slot1)
   );

   rxts_hdr_shift #(.TIME_W(TIME_W)) u_hdr (
      .clk(clk), .rst_n(rst_n), .load_i(load), .adv_i(adv),
      .slot0_i(slot0), .slot1_i(slot1), .byte_o(hdr_byte),
      .first_o(hdr_first), .last_o(hdr_last), .hdr_o(hdr_word)
   );

   rxts_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .stamp_ok_i(stamp_en && q_en),
      .in_valid_i(in_valid), .in_data_i(in_data), .in_sof_i(in_sof),
      .in_eof_i(in_eof), .in_ready_o(in_ready), .out_ready_i(out_ready),
      .out_valid_o(out_valid), .out_data_o(out_data), .out_sof_o(out_sof),
      .out_eof_o(out_eof), .hdr_byte_i(hdr_byte), .hdr_first_i(hdr_first),
      .hdr_last_i(hdr_last), .load_o(load), .adv_o(adv),
      .hdr_active_o(hdr_active)
   );
endmodule

// File: rtl/rxts_prepend_chk.sv
module rxts_prepend_chk #(
   parameter int unsigned TIME_W = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                stamp_en,
   input logic                in_valid,
   input logic                in_ready,
   input logic [7:0]          in_data,
   input logic                out_valid,
   input logic                out_ready,
   input logic [7:0]          out_data,
   input logic                out_sof,
   input logic                out_eof,
   input logic                hdr_active,
   input logic [2*TIME_W-1:0] hdr_word
);
   localparam int unsigned HDR_BYTES = 2 * TIME_W / 8;

   logic [15:0] hdr_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  hdr_cnt <= '0;
      else if (hdr_active && out_valid && out_ready) hdr_cnt <= hdr_cnt + 1'b1;
      else if (!hdr_active)                        hdr_cnt <= '0;
   end

   // R2: a header run transfers exactly HDR_BYTES bytes
   p_hdr_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hdr_active) |-> hdr_cnt == 16'(HDR_BYTES));

   // R8: no input byte is taken while the header is emitted
   p_no_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_active |-> !(in_valid && in_ready));

   // R8: a stalled output byte holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_active && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

   // R7: captured time does not move during the header
   p_time_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_active && $past(hdr_active)) |-> $stable(hdr_word));

   // R9: the header opens with a start flag
   p_sof_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hdr_active) |-> (out_valid && out_sof && !out_eof));

   // R5: global disable leaves the stream untouched
   p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stamp_en && !hdr_active) |-> (out_valid == in_valid && out_data == in_data));
endmodule

bind rxts_prepend rxts_prepend_chk #(.TIME_W(TIME_W)) u_rxts_chk (
   .clk(clk), .rst_n(rst_n), .stamp_en(stamp_en), .in_valid(in_valid),
   .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
   .out_eof(out_eof), .hdr_active(hdr_active), .hdr_word(hdr_word)
);

// File: tb/tb_rxts_prepend.sv
module tb_rxts_prepend;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         stamp_en = 1'b0;
   logic [3:0]   q_stamp_en = 4'b0111;
   logic [3:0]   q_sel0 = 4'b0110;
   logic [3:0]   q_sel1 = 4'b0100;
   logic [127:0] timer_bus;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [7:0]   in_data = 8'h00;
   logic         in_sof = 1'b0;
   logic         in_eof = 1'b0;
   logic [1:0]   in_queue = 2'd0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [7:0]   out_data;
   logic         out_sof;
   logic         out_eof;

   logic [63:0]  tmr0 = 64'h0123_4567_89AB_0000;
   logic [63:0]  tmr1 = 64'hFEDC_0000_0000_8000;
   assign timer_bus = {tmr1, tmr0};

   int  tests = 0;
   int  fails = 0;
   int  cyc = 0;
   bit  stall_mode = 1'b0;

   logic [7:0] ob [0:63];
   bit         os [0:63];
   bit         oe [0:63];
   int         on = 0;
   bit         coll_on = 1'b0;
   logic [63:0] snap0, snap1;
   int         first_waits;

   rxts_prepend dut (
      .clk(clk), .rst_n(rst_n), .stamp_en(stamp_en), .q_stamp_en(q_stamp_en),
      .q_sel0(q_sel0), .q_sel1(q_sel1), .timer_bus(timer_bus),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sof(in_sof), .in_eof(in_eof), .in_queue(in_queue),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof)
   );

   always #5 clk = ~clk;

   // Sources and downstream ready change at the falling edge.
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         tmr0 <= tmr0 + 64'd5;
         tmr1 <= tmr1 + 64'h0000_0001_0000_0003;
         out_ready <= stall_mode ? ((cyc % 3) != 0) : 1'b1;
      end
   end

   // Output collector.
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (coll_on && out_valid && out_ready && on < 64) begin
            ob[on] = out_data;
            os[on] = out_sof;
            oe[on] = out_eof;
            on++;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_frame(int q, int len, logic [7:0] seed);
      coll_on = 1'b1;
      on = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         #1;
         in_valid = 1'b1;
         in_data  = seed + 8'(i * 7);
         in_sof   = (i == 0);
         in_eof   = (i == len - 1);
         in_queue = 2'(q);
         if (i == 0) begin
            snap0 = tmr0;
            snap1 = tmr1;
            first_waits = 0;
         end
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #2;
            if (i == 0) first_waits++;
         end
      end
      @(negedge clk);
      #1;
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
      repeat (4) @(negedge clk);
      #4;
      coll_on = 1'b0;
   endtask

   task automatic check_frame(bit stamped, int len, logic [7:0] seed,
                              logic [63:0] e0, logic [63:0] e1, string req);
      int hl;
      logic [127:0] hw;
      hl = stamped ? 16 : 0;
      hw = {e1, e0};
      chk(on == hl + len, req, "byte count", on, hl + len);
      for (int k = 0; k < on && k < hl + len; k++) begin
         logic [7:0] eb;
         eb = (k < hl) ? hw[k*8 +: 8] : seed + 8'((k - hl) * 7);
         chk(ob[k] == eb, (k < hl) ? "R3" : req, "byte value", ob[k], eb);
         chk(os[k] == (k == 0), "R9", "sof flag", os[k], (k == 0));
         chk(oe[k] == (k == hl + len - 1), "R9", "eof flag", oe[k], (k == hl + len - 1));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      #3;
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(out_sof == 1'b0, "R1", "out_sof after reset", out_sof, 0);
      chk(in_ready == out_ready, "R1", "in_ready follows out_ready", in_ready, out_ready);
   endtask

   task automatic t_stamp_q0();
      stamp_en = 1'b1;
      drive_frame(0, 5, 8'h10);
      chk(first_waits == 17, "R8", "cycles until start byte taken", first_waits, 17);
      // R4: both selectors at 0 give source 0 twice
      check_frame(1'b1, 5, 8'h10, snap0, snap0, "R2");
   endtask

   task automatic t_stamp_q1_mixed();
      drive_frame(1, 6, 8'h40);
      check_frame(1'b1, 6, 8'h40, snap1, snap0, "R4");
   endtask

   task automatic t_stall_q2();
      // R7: sources move each cycle and output stalls; header must match first sight
      stall_mode = 1'b1;
      drive_frame(2, 7, 8'h70);
      check_frame(1'b1, 7, 8'h70, snap1, snap1, "R7");
      chk(first_waits > 17, "R8", "stalled header holds input", first_waits, 18);
      stall_mode = 1'b0;
   endtask

   task automatic t_single_byte();
      drive_frame(0, 1, 8'hA5);
      check_frame(1'b1, 1, 8'hA5, snap0, snap0, "R9");
   endtask

   task automatic t_global_off();
      stamp_en = 1'b0;
      drive_frame(1, 4, 8'hC0);
      check_frame(1'b0, 4, 8'hC0, 64'd0, 64'd0, "R5");
      chk(first_waits == 0, "R5", "no hold-off when disabled", first_waits, 0);
      stamp_en = 1'b1;
   endtask

   task automatic t_queue_off();
      drive_frame(3, 5, 8'hE0);
      check_frame(1'b0, 5, 8'hE0, 64'd0, 64'd0, "R6");
      chk(first_waits == 0, "R6", "no hold-off on disabled queue", first_waits, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R2: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stamp_q0();
      t_stamp_q1_mixed();
      t_stall_q2();
      t_single_byte();
      t_global_off();
      t_queue_off();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule